// File: doc/BRIEF.md
# Delta-Sigma Conversion Sequencer

This block is the digital controller that sits beside an abstracted delta-sigma modulator. It holds a small configuration made up of a gain code, a rate code and a one-shot/continuous mode bit. From that configuration it sequences conversions. After any reset it first waits out an analog settling delay. It then runs conversions back to back in continuous mode, or exactly one per start command in one-shot mode. It drives run, start, calibration-window and standby controls to the modulator. When a conversion completes it captures the modulator's result and raises a ready flag.

The rate code sets both the length of a conversion and the resolution of the captured result. The captured word is sign-extended from that resolution. All durations are counted in system clock ticks and derived from a clock-frequency parameter. A low power-good input and a general-call reset request from the serial bus both restore the same state that the asynchronous reset gives. Any configuration write aborts the conversion in progress and restarts sequencing under the new settings.

Top module: `adc_conv_seq`

## Requirements
- R1: Rate code k (0..3) selects 240, 60, 15 or 3.75 conversions per second: a conversion lasts (CLK_HZ/240)·4^k clock ticks and yields a result of 12 + 2k bits, reported on result_bits.
- R2: The 2-bit gain code (0..3 meaning ×1, ×2, ×4, ×8) and the rate code are presented on mod_gain and mod_rate, and they do not change during a conversion.
- R3: While rst_n is low, or in the cycle after power_good is sampled low, the configuration is gain 0, rate 0 and continuous mode, and mod_run, mod_standby and data_ready are low.
- R4: A general-call reset request (gc_reset high at a clock edge) has exactly the effect of a power-on reset, including a fresh settling delay.
- R5: After any reset, mod_run stays low for SETTLE_TICKS = (CLK_HZ/1000)·SETTLE_US/1000 clock cycles (at least 1).
- R6: In continuous mode the next conversion starts (mod_start) in the same cycle in which the previous one's result becomes ready.
- R7: In one-shot mode exactly one conversion runs, after which mod_standby is high and mod_run is low until a configuration write with the start bit set.
- R8: Every conversion begins with a calibration window: cal_active is high for the first (conversion ticks >> CAL_SHIFT) cycles of it.
- R9: data_ready is set when a conversion completes and then holds until rd_ack, a configuration write or a reset clears it; completion wins over rd_ack in the same cycle.
- R10: At completion, result takes mod_data sign-extended from bit (result_bits−1).
- R11: A configuration write outside the settling delay aborts any conversion and clears data_ready. It restarts at once in continuous mode, or in one-shot mode when the start bit is set; otherwise it goes to standby.
- R12: A configuration write during the settling delay takes effect without shortening it; a one-shot start written then is held and launches one conversion when settling ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-good indication; low resets the block |
| gc_reset | input | 1 | General-call reset request from the serial bus |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_gain | input | 2 | Gain code to write |
| cfg_rate | input | 2 | Rate code to write |
| cfg_oneshot | input | 1 | 1 = one-shot mode, 0 = continuous |
| cfg_start | input | 1 | Start request for one-shot mode |
| rd_ack | input | 1 | Result has been read; clears data_ready |
| mod_data | input | 18 | Right-aligned raw result from the modulator |
| mod_gain | output | 2 | Gain code to the modulator |
| mod_rate | output | 2 | Rate code to the modulator |
| mod_run | output | 1 | A conversion is in progress |
| mod_start | output | 1 | First cycle of a conversion |
| cal_active | output | 1 | Calibration window of the running conversion |
| mod_standby | output | 1 | Modulator may power down |
| data_ready | output | 1 | A captured result is waiting |
| result | output | 18 | Captured, sign-extended result |
| result_bits | output | 5 | Resolution of the captured result |

## Verification
Every output comes from a register stage of one clock. A reset, write or read sampled at an edge is therefore visible in the cycle after it, while a conversion launched at that edge shows mod_start at once and ends exactly conversion-ticks cycles later. The bench drives inputs on falling edges. It advances a cycle model on each rising edge, and on the next falling edge it compares every output with that model, so each expectation lands in the very cycle the requirements place it. Directed runs also count cycles explicitly for the settling delay (7 at the bench clock setting), the conversion lengths of all four rates (100, 400, 1600, 6400) and the 12-cycle calibration window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int RES_MAX = 18;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_CONV   = 2'd1,
    ST_STBY   = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [1:0] gain;
    logic [1:0] rate;
    logic       oneshot;
  } seq_cfg_t;

  localparam seq_cfg_t CFG_DEFAULT = '{gain: 2'd0, rate: 2'd0, oneshot: 1'b0};

  // resolution in bits for a rate code: 12, 14, 16, 18
  function automatic logic [4:0] res_bits(input logic [1:0] rate);
    return 5'(12 + 2 * int'(rate));
  endfunction

  // sign-extend a right-aligned sample of the resolution picked by rate
  function automatic logic [RES_MAX-1:0] sext_res(input logic [RES_MAX-1:0] d,
                                                  input logic [1:0] rate);
    logic [RES_MAX-1:0] r;
    case (rate)
      2'd0:    r = {{6{d[11]}}, d[11:0]};
      2'd1:    r = {{4{d[13]}}, d[13:0]};
      2'd2:    r = {{2{d[15]}}, d[15:0]};
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_rst,
  input  logic     cfg_we,
  input  seq_cfg_t wr_cfg,
  output seq_cfg_t cfg_q,
  output logic     oneshot_eff
);

  seq_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (soft_rst)    cfg_d = CFG_DEFAULT;
    else if (cfg_we) cfg_d = wr_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_DEFAULT;
    else if (soft_rst || cfg_we) cfg_q <= cfg_d;
  end

  // mode in force for decisions taken in this cycle
  assign oneshot_eff = cfg_we ? wr_cfg.oneshot : cfg_q.oneshot;

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int PERIOD_BASE  = 4166,
  parameter int SETTLE_TICKS = 300,
  parameter int CAL_SHIFT    = 3,
  parameter int CNT_W        = 19
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       cnt_clr,
  input  logic       cnt_en,
  input  logic       in_settle,
  input  logic [1:0] rate,
  output logic       terminal,
  output logic       cnt_zero,
  output logic       in_cal
);

  localparam int NRATE = 4;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic [CNT_W-1:0] last_tab [NRATE];
  logic [CNT_W-1:0] cal_tab  [NRATE];

  generate
    for (genvar r = 0; r < NRATE; r++) begin : g_rate
      localparam int TICKS = PERIOD_BASE << (2 * r);
      assign last_tab[r] = CNT_W'(TICKS - 1);
      assign cal_tab[r]  = CNT_W'(TICKS >> CAL_SHIFT);
    end
  endgenerate

  assign limit    = in_settle ? CNT_W'(SETTLE_TICKS - 1) : last_tab[rate];
  assign terminal = (cnt_q == limit);
  assign cnt_zero = (cnt_q == '0);
  assign in_cal   = (cnt_q < cal_tab[rate]);

  always_comb begin
    if (cnt_clr) cnt_d = '0;
    else         cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (soft_rst)           cnt_q <= '0;
    else if (cnt_clr || cnt_en)  cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       cfg_we,
  input  logic       wr_start,
  input  logic       oneshot_eff,
  input  logic       terminal,
  output seq_state_e state_q,
  output logic       cnt_clr,
  output logic       cnt_en,
  output logic       conv_done
);

  seq_state_e state_d;
  logic       pend_q, pend_d;
  logic       start_eff, launch;

  assign start_eff = pend_q | (cfg_we & wr_start);
  assign launch    = ~oneshot_eff | start_eff;

  always_comb begin
    state_d   = state_q;
    pend_d    = 1'b0;
    cnt_clr   = 1'b0;
    conv_done = 1'b0;
    cnt_en    = (state_q != ST_STBY);
    case (state_q)
      ST_SETTLE: begin
        pend_d = start_eff;
        if (terminal) begin
          cnt_clr = 1'b1;
          pend_d  = 1'b0;
          state_d = launch ? ST_CONV : ST_STBY;
        end
      end
      ST_CONV: begin
        if (cfg_we) begin
          cnt_clr = 1'b1;
          state_d = launch ? ST_CONV : ST_STBY;
        end else if (terminal) begin
          conv_done = 1'b1;
          cnt_clr   = 1'b1;
          state_d   = oneshot_eff ? ST_STBY : ST_CONV;
        end
      end
      default: begin
        cnt_clr = 1'b1;
        if (cfg_we && launch) state_d = ST_CONV;
      end
    endcase
    if (soft_rst) begin
      state_d   = ST_SETTLE;
      pend_d    = 1'b0;
      conv_done = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SETTLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result
  import adc_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               conv_done,
  input  logic               clr_req,
  input  logic [1:0]         rate,
  input  logic [RES_MAX-1:0] mod_data,
  output logic               data_ready,
  output logic [RES_MAX-1:0] result,
  output logic [4:0]         result_bits
);

  logic ready_d;
  logic load;

  assign load = conv_done & ~soft_rst;

  always_comb begin
    ready_d = data_ready;
    if (soft_rst)       ready_d = 1'b0;
    else if (conv_done) ready_d = 1'b1;
    else if (clr_req)   ready_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_ready <= 1'b0;
    else        data_ready <= ready_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result      <= '0;
      result_bits <= '0;
    end else if (soft_rst) begin
      result      <= '0;
      result_bits <= '0;
    end else if (load) begin
      result      <= sext_res(mod_data, rate);
      result_bits <= res_bits(rate);
    end
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int CLK_HZ    = 1_000_000,
  parameter int SETTLE_US = 300,
  parameter int CAL_SHIFT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_good,
  input  logic                gc_reset,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_gain,
  input  logic [1:0]          cfg_rate,
  input  logic                cfg_oneshot,
  input  logic                cfg_start,
  input  logic                rd_ack,
  input  logic [RES_MAX-1:0]  mod_data,
  output logic [1:0]          mod_gain,
  output logic [1:0]          mod_rate,
  output logic                mod_run,
  output logic                mod_start,
  output logic                cal_active,
  output logic                mod_standby,
  output logic                data_ready,
  output logic [RES_MAX-1:0]  result,
  output logic [4:0]          result_bits
);

  localparam int PERIOD_BASE  = CLK_HZ / 240;
  localparam int SETTLE_RAW   = (CLK_HZ / 1000) * SETTLE_US / 1000;
  localparam int SETTLE_TICKS = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int PERIOD_MAX   = PERIOD_BASE * 64;
  localparam int CNT_MAX      = (PERIOD_MAX > SETTLE_TICKS) ? PERIOD_MAX : SETTLE_TICKS;
  localparam int CNT_W        = $clog2(CNT_MAX + 1);

  logic       soft_rst;
  seq_cfg_t   wr_cfg, cfg_q;
  logic       oneshot_eff, oneshot_q;
  seq_state_e state_q;
  logic       cnt_clr, cnt_en, conv_done;
  logic       terminal, cnt_zero, in_cal;

  assign soft_rst  = ~pwr_good | gc_reset;
  assign wr_cfg    = '{gain: cfg_gain, rate: cfg_rate, oneshot: cfg_oneshot};
  assign oneshot_q = cfg_q.oneshot;

  adc_seq_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .cfg_we      (cfg_we),
    .wr_cfg      (wr_cfg),
    .cfg_q       (cfg_q),
    .oneshot_eff (oneshot_eff)
  );

  adc_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .cfg_we      (cfg_we),
    .wr_start    (cfg_start),
    .oneshot_eff (oneshot_eff),
    .terminal    (terminal),
    .state_q     (state_q),
    .cnt_clr     (cnt_clr),
    .cnt_en      (cnt_en),
    .conv_done   (conv_done)
  );

  adc_seq_timer #(
    .PERIOD_BASE  (PERIOD_BASE),
    .SETTLE_TICKS (SETTLE_TICKS),
    .CAL_SHIFT    (CAL_SHIFT),
    .CNT_W        (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .cnt_clr   (cnt_clr),
    .cnt_en    (cnt_en),
    .in_settle (state_q == ST_SETTLE),
    .rate      (cfg_q.rate),
    .terminal  (terminal),
    .cnt_zero  (cnt_zero),
    .in_cal    (in_cal)
  );

  adc_seq_result u_result (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .conv_done   (conv_done),
    .clr_req     (cfg_we | rd_ack),
    .rate        (cfg_q.rate),
    .mod_data    (mod_data),
    .data_ready  (data_ready),
    .result      (result),
    .result_bits (result_bits)
  );

  assign mod_gain    = cfg_q.gain;
  assign mod_rate    = cfg_q.rate;
  assign mod_run     = (state_q == ST_CONV);
  assign mod_start   = mod_run & cnt_zero;
  assign cal_active  = mod_run & in_cal;
  assign mod_standby = (state_q == ST_STBY);

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int SETTLE_TICKS = 300
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       gc_reset,
  input logic       cfg_we,
  input logic       rd_ack,
  input logic       oneshot,
  input logic       mod_run,
  input logic       mod_start,
  input logic       cal_active,
  input logic       mod_standby,
  input logic       data_ready,
  input logic [1:0] mod_gain,
  input logic [1:0] mod_rate
);

  int since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since_rst <= 0;
    else if (!pwr_good || gc_reset)   since_rst <= 0;
    else if (since_rst < SETTLE_TICKS) since_rst <= since_rst + 1;
  end

  // R3: power-good low restores the default state
  a_r3_pwr_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!mod_run && !mod_standby && !data_ready && mod_gain == 2'd0 && mod_rate == 2'd0));

  // R4: general-call reset behaves like power-on reset
  a_r4_gc_reset: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> (!mod_run && !mod_standby && !data_ready && mod_gain == 2'd0 && mod_rate == 2'd0));

  // R5: no conversion inside the settling window
  a_r5_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < SETTLE_TICKS) |-> !mod_run);

  // R6: continuous mode starts the next conversion with the ready flag
  a_r6_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(data_ready) && !oneshot) |-> mod_start);

  // R7: a conversion ending on its own in one-shot mode lands in standby with data
  a_r7_oneshot_stby: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mod_run) && $past(pwr_good && !gc_reset && !cfg_we)) |-> (data_ready && mod_standby));

  // R8: every conversion opens with calibration
  a_r8_cal_first: assert property (@(posedge clk) disable iff (!rst_n)
    mod_start |-> cal_active);

  // R9: ready holds until read, write or reset
  a_r9_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && !rd_ack && !cfg_we && pwr_good && !gc_reset) |=> data_ready);

  // R11: a configuration write clears ready
  a_r11_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !data_ready);

  // R2: settings stay fixed across a running conversion
  a_r2_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_run && !mod_start) |-> ($stable(mod_gain) && $stable(mod_rate)));

  a_run_stby_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mod_run, mod_standby}));

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.SETTLE_TICKS(SETTLE_TICKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwr_good    (pwr_good),
  .gc_reset    (gc_reset),
  .cfg_we      (cfg_we),
  .rd_ack      (rd_ack),
  .oneshot     (oneshot_q),
  .mod_run     (mod_run),
  .mod_start   (mod_start),
  .cal_active  (cal_active),
  .mod_standby (mod_standby),
  .data_ready  (data_ready),
  .mod_gain    (mod_gain),
  .mod_rate    (mod_rate)
);

// File: tb/adc_conv_seq_tb.sv
`timescale 1ns/1ps
module adc_conv_seq_tb;

  localparam int CLK_HZ    = 24000;
  localparam int SETTLE_US = 300;
  localparam int SETTLE_T  = (CLK_HZ / 1000) * SETTLE_US / 1000;  // 7

  logic        clk = 1'b0;
  logic        rst_n, pwr_good, gc_reset, cfg_we, cfg_oneshot, cfg_start, rd_ack;
  logic [1:0]  cfg_gain, cfg_rate;
  logic [17:0] mod_data;
  logic [1:0]  mod_gain, mod_rate;
  logic        mod_run, mod_start, cal_active, mod_standby, data_ready;
  logic [17:0] result;
  logic [4:0]  result_bits;

  int n_chk = 0;
  int n_err = 0;
  bit chk_on = 1'b0;

  always #2 clk = ~clk;

  adc_conv_seq #(.CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US), .CAL_SHIFT(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .gc_reset(gc_reset),
    .cfg_we(cfg_we), .cfg_gain(cfg_gain), .cfg_rate(cfg_rate),
    .cfg_oneshot(cfg_oneshot), .cfg_start(cfg_start), .rd_ack(rd_ack),
    .mod_data(mod_data), .mod_gain(mod_gain), .mod_rate(mod_rate),
    .mod_run(mod_run), .mod_start(mod_start), .cal_active(cal_active),
    .mod_standby(mod_standby), .data_ready(data_ready), .result(result),
    .result_bits(result_bits)
  );

  function automatic int f_period(input int rate);
    return (CLK_HZ / 240) << (2 * rate);
  endfunction

  function automatic logic [17:0] f_sext(input logic [17:0] d, input int rate);
    int nb = 12 + 2 * rate;
    logic [17:0] r = d;
    for (int i = nb; i < 18; i++) r[i] = d[nb-1];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle model built from the requirements
  int m_state, m_cnt, m_gain, m_rate, m_bits;
  bit m_os, m_pend, m_ready;
  logic [17:0] m_res;

  task automatic m_reset();
    m_state = 0; m_cnt = 0; m_gain = 0; m_rate = 0; m_os = 0;
    m_pend = 0; m_ready = 0; m_res = '0; m_bits = 0;
  endtask

  task automatic m_step();
    bit os_e, st_e, go, term;
    int rate_now;
    os_e = cfg_we ? cfg_oneshot : m_os;
    st_e = m_pend || (cfg_we && cfg_start);
    go = !os_e || st_e;
    rate_now = m_rate;
    term = (m_cnt == f_period(m_rate) - 1);
    if (cfg_we) begin
      m_gain = int'(cfg_gain); m_rate = int'(cfg_rate); m_os = cfg_oneshot; m_ready = 0;
    end else if (rd_ack) m_ready = 0;
    case (m_state)
      0: begin
        if (m_cnt == SETTLE_T - 1) begin
          m_cnt = 0; m_pend = 0; m_state = go ? 1 : 2;
        end else begin
          m_cnt++; m_pend = st_e;
        end
      end
      1: begin
        m_pend = 0;
        if (cfg_we) begin
          m_cnt = 0; m_state = go ? 1 : 2;
        end else if (term) begin
          m_ready = 1; m_res = f_sext(mod_data, rate_now); m_bits = 12 + 2 * rate_now;
          m_cnt = 0; m_state = m_os ? 2 : 1;
        end else m_cnt++;
      end
      default: begin
        m_pend = 0; m_cnt = 0;
        if (cfg_we && go) m_state = 1;
      end
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else if (!pwr_good || gc_reset) m_reset();
    else m_step();
  end

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R11/R7 run",     mod_run,     m_state == 1);
      chk("R7 standby",     mod_standby, m_state == 2);
      chk("R6 start",       mod_start,   m_state == 1 && m_cnt == 0);
      chk("R8 cal",         cal_active,  m_state == 1 && m_cnt < (f_period(m_rate) >> 3));
      chk("R9 ready",       data_ready,  m_ready);
      chk("R2 gain",        mod_gain,    m_gain);
      chk("R1 rate",        mod_rate,    m_rate);
      if (m_ready) begin
        chk("R10 result",   result,      m_res);
        chk("R1 bits",      result_bits, m_bits);
      end
    end
  end

  task automatic wr(input int g, input int r, input bit os, input bit st);
    cfg_gain = 2'(g); cfg_rate = 2'(r); cfg_oneshot = os; cfg_start = st; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_start = 1'b0;
  endtask

  task automatic count_to_start(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!mod_start && n < 10000);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    rst_n = 0; pwr_good = 1; gc_reset = 0; cfg_we = 0; cfg_gain = 0; cfg_rate = 0;
    cfg_oneshot = 0; cfg_start = 0; rd_ack = 0; mod_data = 18'h2A801;
    repeat (3) @(negedge clk);
    // R3 reset state
    chk("R3 run",     mod_run, 0);
    chk("R3 standby", mod_standby, 0);
    chk("R3 ready",   data_ready, 0);
    chk("R3 gain",    mod_gain, 0);
    chk("R3 rate",    mod_rate, 0);
    chk_on = 1;
    rst_n = 1;
    n = 0;
    while (!mod_run) begin @(negedge clk); n++; end
    chk("R5 settle length", n, SETTLE_T);
    count_to_start(n);
    chk("R1 R6 period rate0", n, f_period(0));
    chk("R6 ready with next start", data_ready, 1);
    chk("R1 bits rate0", result_bits, 12);
    chk("R10 sext rate0", result, 18'h3F801);
    // R8 calibration window length
    n = 0;
    while (cal_active) begin @(negedge clk); n++; end
    chk("R8 cal length", n, f_period(0) >> 3);
    // R2/R11 write restarts at once in continuous mode
    wr(2, 1, 0, 0);
    chk("R11 restart", mod_start, 1);
    chk("R11 ready cleared", data_ready, 0);
    chk("R2 gain out", mod_gain, 2);
    count_to_start(n);
    chk("R1 period rate1", n, f_period(1));
    chk("R1 bits rate1", result_bits, 14);
    // R7 one-shot
    wr(1, 0, 1, 1);
    chk("R7 launch", mod_start, 1);
    n = 0;
    while (!mod_standby) begin @(negedge clk); n++; end
    chk("R7 single conversion", n, f_period(0));
    chk("R7 ready", data_ready, 1);
    repeat (50) @(negedge clk);
    chk("R7 stays standby", mod_standby, 1);
    chk("R7 no run", mod_run, 0);
    rd_ack = 1; @(negedge clk); rd_ack = 0;
    chk("R9 read clears", data_ready, 0);
    wr(1, 0, 1, 0);
    chk("R11 no start without start bit", mod_run, 0);
    // R4 general-call reset
    wr(3, 0, 0, 0);
    repeat (20) @(negedge clk);
    gc_reset = 1; @(negedge clk); gc_reset = 0;
    chk("R4 run", mod_run, 0);
    chk("R4 gain", mod_gain, 0);
    n = 0;
    while (!mod_run) begin @(negedge clk); n++; end
    chk("R4 R5 settle again", n, SETTLE_T);
    // R12 one-shot start written during settling
    pwr_good = 0; repeat (3) @(negedge clk);
    pwr_good = 1;
    wr(0, 0, 1, 1);
    n = 1;
    while (!mod_run) begin @(negedge clk); n++; end
    chk("R12 held start", n, SETTLE_T);
    pwr_good = 0; @(negedge clk); pwr_good = 1;
    wr(0, 0, 1, 0);
    repeat (SETTLE_T + 5) @(negedge clk);
    chk("R12 standby after settle", mod_standby, 1);
    chk("R12 no run", mod_run, 0);
    // R1 slow rates
    wr(0, 2, 0, 0);
    count_to_start(n);
    chk("R1 period rate2", n, f_period(2));
    chk("R1 bits rate2", result_bits, 16);
    wr(0, 3, 0, 0);
    count_to_start(n);
    chk("R1 period rate3", n, f_period(3));
    chk("R1 bits rate3", result_bits, 18);
    // random phase, checked by the model every cycle
    for (int i = 0; i < 40000; i++) begin
      mod_data = 18'($urandom);
      pwr_good = ($urandom % 3000) != 0;
      gc_reset = ($urandom % 3000) == 0;
      rd_ack   = ($urandom % 16) == 0;
      cfg_we   = ($urandom % 250) == 0;
      cfg_gain = 2'($urandom);
      cfg_rate = (($urandom % 8) == 0) ? 2'd2 : 2'($urandom % 2);
      cfg_oneshot = 1'($urandom);
      cfg_start   = 1'($urandom);
      @(negedge clk);
    end
    cfg_we = 0; rd_ack = 0; gc_reset = 0; pwr_good = 1;
    @(negedge clk);
    report();
  end

endmodule